// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the hardware steps a small microcontroller core takes when it enters an interrupt. A request comes in one of three kinds. A fixed request supplies a table address directly. A software request supplies a vector number, which is resolved against a table base register. A peripheral request supplies a vector number together with the address of that peripheral's control byte.

On acceptance the block captures the current stack pointer, flag word and program counter. It writes the lowered stack pointer and pushes a return frame. The frame layout is either the compact 16-bit-address layout or the wide 24-bit-address layout. The block then reads the new program counter from the table and commits the new program counter and flags together.

All memory traffic uses one byte-wide port with a ready handshake, one byte per completed transfer. The register updates leave the block as write-enable and value pairs, for an external register file.

Top module: `irq_entry_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no request, busy_o, done_o, mem_req_o, sp_we_o, flg_we_o and pc_we_o are all 0. A reset in the middle of an entry aborts it at once.
- R2: A request on req_i is accepted only when busy_o is 0, and busy_o is 1 from the next cycle. kind_i encodes 0 for fixed, 1 for software and 2 for peripheral. A request while busy_o is 1 is ignored: no second entry starts and the results are unchanged.
- R3: sp_o equals the captured SP minus 4 in 16-bit mode (mode24_i=0) or minus 6 in 24-bit mode. sp_we_o is high for one cycle, and that cycle comes before the first stack write.
- R4: In 16-bit mode the bytes at new SP+0..+3 are PC[7:0], PC[15:8], FLG[7:0], and a fourth byte. The fourth byte has FLG[7:4] OR PC[19:16] in bits 3:0 and zero in bits 7:4.
- R5: In 24-bit mode the bytes at new SP+0..+5 are PC[7:0], PC[15:8], PC[23:16], 0x00, FLG[7:0], FLG[15:8].
- R6: The table entry address is fix_addr_i for fixed requests and intb_i + 4*vec_i otherwise. pc_o is the three bytes read from it, lowest address as the least significant byte.
- R7: The flag word written is the captured FLG with bit 6 (interrupt enable) and bit 1 (debug) cleared. Bit 7 (stack select) is cleared for fixed and peripheral requests, and for software requests with vec_i <= 31. It is kept for software requests with vec_i > 31.
- R8: For peripheral requests the control byte at ic_addr_i is read before the first stack write. Flag bits 14:12 become its bits 2:0, and the other flag bits follow R7. The byte is written back with bit 3 cleared and its other bits unchanged.
- R9: pc_we_o, flg_we_o and done_o are high together for exactly one cycle, and busy_o is 0 in the following cycle.
- R10: A memory access holds its address, direction and write data until mem_rdy_i is high. With mem_rdy_i held at 1, done_o appears 4 + N + 2P cycles after the accepting edge, where N is the frame size (4 or 6) and P is 1 for peripheral requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Interrupt entry request |
| kind_i | input | 2 | Request kind: 0 fixed, 1 software, 2 peripheral |
| vec_i | input | 8 | Vector number |
| fix_addr_i | input | 24 | Table entry address for fixed requests |
| ic_addr_i | input | 24 | Peripheral control byte address |
| mode24_i | input | 1 | 1 selects the 24-bit frame, 0 the 16-bit frame |
| sp_i | input | 24 | Current stack pointer |
| flg_i | input | 16 | Current flag word |
| pc_i | input | 24 | Current program counter |
| intb_i | input | 24 | Vector table base |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write when 1, read when 0 |
| mem_addr_o | output | 24 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_rdata_i | input | 8 | Memory read byte |
| mem_rdy_i | input | 1 | Access completes this cycle |
| sp_we_o | output | 1 | Stack pointer write enable |
| sp_o | output | 24 | New stack pointer |
| flg_we_o | output | 1 | Flag word write enable |
| flg_o | output | 16 | New flag word |
| pc_we_o | output | 1 | Program counter write enable |
| pc_o | output | 24 | New program counter |

## Verification
The program counter, flag word and done pulse arrive on the edge that ends the last table read, or the control-byte write-back for peripheral requests. With ready held high this is 4 + N + 2P cycles after acceptance, and the bench counts cycles from the accepting edge to confirm that figure. Under a random ready pattern, the bench waits for done_o and samples pc_o and flg_o on the falling edge of that same cycle. It checks busy_o one cycle later. It reads the stack frame and control byte from its memory model only once the entry has completed. The SP write and the control byte read are timestamped at the edge where they happen, and those timestamps are compared with the first stack write.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    KIND_FIXED  = 2'd0,
    KIND_SOFT   = 2'd1,
    KIND_PERIPH = 2'd2
  } irq_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IC_RD,
    ST_SP_WR,
    ST_PUSH,
    ST_VEC_RD,
    ST_IC_WR,
    ST_COMMIT
  } seq_state_e;

  localparam int FLG_BIT_D    = 1;
  localparam int FLG_BIT_I    = 6;
  localparam int FLG_BIT_U    = 7;
  localparam int FLG_IPL_LSB  = 12;
  localparam int IC_REQ_BIT   = 3;
  localparam int SOFT_U_LIMIT = 31;
endpackage

// File: rtl/irq_vec_addr.sv
module irq_vec_addr
  import irq_entry_pkg::*;
#(
  parameter int AW = 24,
  parameter int VW = 8
) (
  input  logic [1:0]    kind_i,
  input  logic [VW-1:0] vec_i,
  input  logic [AW-1:0] fix_addr_i,
  input  logic [AW-1:0] intb_i,
  output logic [AW-1:0] vaddr_o
);
  localparam int ENTRY_SHIFT = 2;

  logic [AW-1:0] scaled;
  assign scaled  = AW'(vec_i) << ENTRY_SHIFT;
  assign vaddr_o = (kind_i == KIND_SOFT || kind_i == KIND_PERIPH) ? intb_i + scaled
                                                                   : fix_addr_i;
endmodule

// File: rtl/irq_frame_byte.sv
module irq_frame_byte #(
  parameter int PW = 24,
  parameter int FW = 16
) (
  input  logic          mode24_i,
  input  logic [2:0]    idx_i,
  input  logic [PW-1:0] pc_i,
  input  logic [FW-1:0] flg_i,
  output logic [7:0]    byte_o
);
  logic [31:0] pc_w;
  logic [15:0] flg_w;
  assign pc_w  = 32'(pc_i);
  assign flg_w = 16'(flg_i);

  always_comb begin
    byte_o = 8'h00;
    if (mode24_i) begin
      case (idx_i)
        3'd0: byte_o = pc_w[7:0];
        3'd1: byte_o = pc_w[15:8];
        3'd2: byte_o = pc_w[23:16];
        3'd3: byte_o = pc_w[31:24];
        3'd4: byte_o = flg_w[7:0];
        3'd5: byte_o = flg_w[15:8];
        default: byte_o = 8'h00;
      endcase
    end else begin
      case (idx_i)
        3'd0: byte_o = pc_w[7:0];
        3'd1: byte_o = pc_w[15:8];
        3'd2: byte_o = flg_w[7:0];
        3'd3: byte_o = {4'h0, flg_w[7:4] | pc_w[19:16]};  // shared nibble byte
        default: byte_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/irq_flag_upd.sv
module irq_flag_upd
  import irq_entry_pkg::*;
#(
  parameter int FW = 16,
  parameter int VW = 8
) (
  input  logic [1:0]    kind_i,
  input  logic [VW-1:0] vec_i,
  input  logic [FW-1:0] flg_i,
  input  logic [7:0]    ic_i,
  output logic [FW-1:0] flg_o
);
  logic clr_u;
  assign clr_u = (kind_i != KIND_SOFT) || (32'(vec_i) <= SOFT_U_LIMIT);

  always_comb begin
    flg_o = flg_i;
    flg_o[FLG_BIT_I] = 1'b0;
    flg_o[FLG_BIT_D] = 1'b0;
    if (clr_u) flg_o[FLG_BIT_U] = 1'b0;
    if (kind_i == KIND_PERIPH) flg_o[FLG_IPL_LSB +: 3] = ic_i[2:0];
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int AW = 24,
  parameter int VW = 8,
  parameter int FW = 16,
  parameter int PW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    kind_i,
  input  logic [VW-1:0] vec_i,
  input  logic [AW-1:0] fix_addr_i,
  input  logic [AW-1:0] ic_addr_i,
  input  logic          mode24_i,
  input  logic [AW-1:0] sp_i,
  input  logic [FW-1:0] flg_i,
  input  logic [PW-1:0] pc_i,
  input  logic [AW-1:0] intb_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  input  logic          mem_rdy_i,
  output logic          sp_we_o,
  output logic [AW-1:0] sp_o,
  output logic          flg_we_o,
  output logic [FW-1:0] flg_o,
  output logic          pc_we_o,
  output logic [PW-1:0] pc_o
);
  localparam int FRAME16  = 4;
  localparam int FRAME24  = 6;
  localparam int VEC_LEN  = 3;
  localparam int IDX_W    = 3;

  seq_state_e     state_q, state_d;
  logic [1:0]     kind_q;
  logic [VW-1:0]  vec_q;
  logic           mode_q;
  logic [AW-1:0]  sp_q, vaddr_q, ic_addr_q, vaddr_d, sp_new;
  logic [FW-1:0]  flg_q;
  logic [PW-1:0]  pc_q, npc_q;
  logic [7:0]     ic_q, frame_byte;
  logic [IDX_W-1:0] idx_q, idx_last;
  logic           xfer, is_periph, accept;

  irq_vec_addr #(.AW(AW), .VW(VW)) u_vec (
    .kind_i(kind_i), .vec_i(vec_i), .fix_addr_i(fix_addr_i),
    .intb_i(intb_i), .vaddr_o(vaddr_d)
  );

  irq_frame_byte #(.PW(PW), .FW(FW)) u_frame (
    .mode24_i(mode_q), .idx_i(idx_q), .pc_i(pc_q), .flg_i(flg_q), .byte_o(frame_byte)
  );

  irq_flag_upd #(.FW(FW), .VW(VW)) u_flag (
    .kind_i(kind_q), .vec_i(vec_q), .flg_i(flg_q), .ic_i(ic_q), .flg_o(flg_o)
  );

  assign accept    = req_i && (state_q == ST_IDLE);
  assign is_periph = (kind_q == KIND_PERIPH);
  assign xfer      = mem_req_o && mem_rdy_i;
  assign sp_new    = sp_q - (mode_q ? AW'(FRAME24) : AW'(FRAME16));
  assign idx_last  = mode_q ? IDX_W'(FRAME24 - 1) : IDX_W'(FRAME16 - 1);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = (kind_i == KIND_PERIPH) ? ST_IC_RD : ST_SP_WR;
      ST_IC_RD:  if (xfer) state_d = ST_SP_WR;
      ST_SP_WR:  state_d = ST_PUSH;
      ST_PUSH:   if (xfer && idx_q == idx_last) state_d = ST_VEC_RD;
      ST_VEC_RD: if (xfer && idx_q == IDX_W'(VEC_LEN - 1))
                   state_d = is_periph ? ST_IC_WR : ST_COMMIT;
      ST_IC_WR:  if (xfer) state_d = ST_COMMIT;
      ST_COMMIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= '0;
      vec_q     <= '0;
      mode_q    <= 1'b0;
      sp_q      <= '0;
      flg_q     <= '0;
      pc_q      <= '0;
      vaddr_q   <= '0;
      ic_addr_q <= '0;
      ic_q      <= '0;
      idx_q     <= '0;
      npc_q     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        kind_q    <= kind_i;
        vec_q     <= vec_i;
        mode_q    <= mode24_i;
        sp_q      <= sp_i;
        flg_q     <= flg_i;
        pc_q      <= pc_i;
        vaddr_q   <= vaddr_d;
        ic_addr_q <= ic_addr_i;
        idx_q     <= '0;
      end
      if (state_q == ST_IC_RD && xfer) ic_q <= mem_rdata_i;
      if (state_q == ST_PUSH && xfer)
        idx_q <= (idx_q == idx_last) ? '0 : idx_q + 1'b1;
      if (state_q == ST_VEC_RD && xfer) begin
        idx_q <= idx_q + 1'b1;
        npc_q[8*idx_q +: 8] <= mem_rdata_i;  // little-endian assembly
      end
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      ST_IC_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ic_addr_q;
      end
      ST_PUSH: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_new + AW'(idx_q);
        mem_wdata_o = frame_byte;
      end
      ST_VEC_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = vaddr_q + AW'(idx_q);
      end
      ST_IC_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ic_addr_q;
        mem_wdata_o = ic_q & ~(8'h1 << IC_REQ_BIT);
      end
      default: ;
    endcase
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign sp_we_o  = (state_q == ST_SP_WR);
  assign sp_o     = sp_new;
  assign done_o   = (state_q == ST_COMMIT);
  assign flg_we_o = done_o;
  assign pc_we_o  = done_o;
  assign pc_o     = npc_q;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !sp_we_o && !pc_we_o && !flg_we_o);

  p_hold_access_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_sp_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |=> !sp_we_o && mem_req_o && mem_we_o);

  p_commit_together_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pc_we_o && flg_we_o && busy_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  p_flags_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flg_we_o |-> !flg_o[FLG_BIT_I] && !flg_o[FLG_BIT_D]);

  p_ic_req_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IC_WR) |-> mem_we_o && !mem_wdata_o[IC_REQ_BIT]);
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [7:0]  vec_i = '0;
  logic [23:0] fix_addr_i = '0, ic_addr_i = '0, sp_i = '0, pc_i = '0, intb_i = '0;
  logic        mode24_i = 1'b0;
  logic [15:0] flg_i = '0;
  logic        busy_o, done_o, mem_req_o, mem_we_o, sp_we_o, flg_we_o, pc_we_o;
  logic [23:0] mem_addr_o, sp_o, pc_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic        mem_rdy_i = 1'b1;
  logic [15:0] flg_o;

  int checks = 0, failures = 0;
  bit rdy_rand = 1'b0;
  logic [7:0] mem [1024];

  irq_entry_seq dut (.*);

  always #10 clk_i = ~clk_i;

  assign mem_rdata_i = mem[mem_addr_o[9:0]];

  int cyc = 0, sp_cyc, push_cyc, icrd_cyc;
  logic [23:0] sp_seen, stk_lo, stk_hi, ic_watch;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (sp_we_o) begin sp_cyc <= cyc; sp_seen <= sp_o; end
    if (mem_req_o && mem_rdy_i) begin
      if (mem_we_o) begin
        mem[mem_addr_o[9:0]] <= mem_wdata_o;
        if (mem_addr_o >= stk_lo && mem_addr_o < stk_hi && push_cyc < 0) push_cyc <= cyc;
      end else if (mem_addr_o == ic_watch && icrd_cyc < 0) icrd_cyc <= cyc;
    end
  end

  always @(negedge clk_i) mem_rdy_i <= rdy_rand ? ($urandom % 3 != 0) : 1'b1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_flags(input logic [1:0] k, input logic [7:0] v,
                                            input logic [15:0] f, input logic [7:0] ic);
    logic [15:0] r = f;
    r[6] = 1'b0; r[1] = 1'b0;
    if (k != 2'd1 || v <= 8'd31) r[7] = 1'b0;
    if (k == 2'd2) r[14:12] = ic[2:0];
    return r;
  endfunction

  function automatic logic [7:0] exp_frame(input bit m24, input int i,
                                           input logic [23:0] p, input logic [15:0] f);
    if (m24) begin
      case (i)
        0: return p[7:0];
        1: return p[15:8];
        2: return p[23:16];
        3: return 8'h00;
        4: return f[7:0];
        default: return f[15:8];
      endcase
    end
    case (i)
      0: return p[7:0];
      1: return p[15:8];
      2: return f[7:0];
      default: return {4'h0, f[7:4] | p[19:16]};
    endcase
  endfunction

  task automatic run_one(input logic [1:0] k, input logic [7:0] v, input logic [23:0] fa,
                         input logic [23:0] ica, input bit m24, input logic [23:0] sp,
                         input logic [15:0] f, input logic [23:0] p,
                         input bit chk_lat, input bit extra_req);
    logic [23:0] va = (k == 2'd0) ? fa : 24'h100 + {14'd0, v, 2'b00};
    logic [23:0] epc = {mem[va[9:0] + 2], mem[va[9:0] + 1], mem[va[9:0]]};
    logic [7:0] ic0 = mem[ica[9:0]];
    int n = m24 ? 6 : 4;
    logic [23:0] nsp = sp - 24'(n);
    int lat = 0, dones = 0;
    @(negedge clk_i);
    stk_lo = nsp; stk_hi = sp; ic_watch = (k == 2'd2) ? ica : 24'hFFFFFF;
    push_cyc = -1; icrd_cyc = -1; sp_cyc = -1;
    kind_i = k; vec_i = v; fix_addr_i = fa; ic_addr_i = ica; mode24_i = m24;
    sp_i = sp; flg_i = f; pc_i = p; intb_i = 24'h100; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after accept", 32'(busy_o), 1);
    lat = 1;
    while (!done_o && lat < 300) begin
      if (extra_req && lat == 3) begin
        req_i = 1'b1; kind_i = 2'd0; fix_addr_i = 24'h0; sp_i = 24'h2F0; mode24_i = ~m24;
      end else req_i = 1'b0;
      @(negedge clk_i);
      lat++;
    end
    req_i = 1'b0;
    chk(done_o == 1'b1, "R9 done seen", 32'(done_o), 1);
    chk(pc_we_o && flg_we_o, "R9 pc/flg write together", {pc_we_o, flg_we_o}, 2'b11);
    chk(pc_o == epc, "R6 new pc", pc_o, epc);
    chk(flg_o == exp_flags(k, v, f, ic0), (k == 2'd2) ? "R8 ipl flags" : "R7 flags",
        flg_o, exp_flags(k, v, f, ic0));
    if (chk_lat)
      chk(lat == 5 + n + ((k == 2'd2) ? 2 : 0), "R10 latency", lat, 5 + n + ((k == 2'd2) ? 2 : 0));
    @(negedge clk_i);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R9 done single pulse", {busy_o, done_o}, 0);
    chk(sp_seen == nsp, "R3 sp value", sp_seen, nsp);
    chk(sp_cyc >= 0 && sp_cyc < push_cyc, "R3 sp before push", sp_cyc, push_cyc);
    for (int i = 0; i < n; i++)
      chk(mem[nsp[9:0] + 10'(i)] == exp_frame(m24, i, p, f), m24 ? "R5 frame byte" : "R4 frame byte",
          mem[nsp[9:0] + 10'(i)], exp_frame(m24, i, p, f));
    if (k == 2'd2) begin
      chk(mem[ica[9:0]] == (ic0 & 8'hF7), "R8 control byte", mem[ica[9:0]], ic0 & 8'hF7);
      chk(icrd_cyc >= 0 && icrd_cyc < push_cyc, "R8 control read first", icrd_cyc, push_cyc);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      dones += done_o;
    end
    if (extra_req) chk(dones == 0 && busy_o == 0, "R2 busy request ignored", dones, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o && !sp_we_o && !flg_we_o && !pc_we_o,
        "R1 in reset", {busy_o, done_o, mem_req_o, sp_we_o, flg_we_o, pc_we_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !mem_req_o, "R1 idle after reset", {busy_o, mem_req_o}, 0);
    // directed corners
    run_one(2'd1, 8'd31, 0, 0, 1'b0, 24'h280, 16'h70F0, 24'h0A1234, 1, 0);
    run_one(2'd1, 8'd32, 0, 0, 1'b0, 24'h280, 16'hFFFF, 24'h0F5678, 1, 0);
    run_one(2'd0, 8'd0, 24'h40, 0, 1'b1, 24'h260, 16'h00C2, 24'hABCDEF, 1, 0);
    run_one(2'd2, 8'd9, 0, 24'h310, 1'b1, 24'h250, 16'hFFFF, 24'h123456, 1, 0);
    run_one(2'd2, 8'd50, 0, 24'h320, 1'b0, 24'h240, 16'h0000, 24'h08FFFF, 1, 1);
    // mid-entry reset
    @(negedge clk_i);
    kind_i = 2'd0; fix_addr_i = 24'h80; sp_i = 24'h270; mode24_i = 1'b1; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(!busy_o && !mem_req_o && !sp_we_o, "R1 reset aborts", {busy_o, mem_req_o, sp_we_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o, "R1 idle after abort", 32'(busy_o), 0);
    // random
    for (int t = 0; t < 60; t++) begin
      logic [1:0] k = 2'($urandom % 3);
      rdy_rand = (t % 2 == 1);
      run_one(k, 8'($urandom % 64), 24'({$urandom % 64, 2'b00}),
              24'h300 + 24'($urandom % 200), 1'($urandom), 24'h210 + 24'($urandom % 200),
              16'($urandom), 24'($urandom), !rdy_rand, (t % 7 == 3));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule